// File: doc/BRIEF.md
# Cache Event Counter Unit

This unit sits beside a cache controller and counts the events that the controller reports as one-cycle pulses on a 16-bit input vector. It has two identical 32-bit counters. Each counter has its own configuration word. That word picks one event line and sets how the counter raises an interrupt. A shared control word starts and stops all counting together, and it can clear either counter with a single write.

Software reaches the unit through a plain register port. A write takes effect at the next clock edge, and a read returns data in the same cycle. The counters never wrap: they stop at all ones. A counter's value can be loaded only while its event select is zero. The interrupt logic has three parts: raw status bits, a mask, and a clear register where writing a 1 clears the matching bit. The interrupt output is a level signal. A separate monitor-enable input gates the whole unit. While it is low, nothing counts and no interrupt is raised.

Top module: `cache_evt_mon`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. Word addresses: 0 control, 1 counter-1 config, 2 counter-0 config, 3 counter-1 value, 4 counter-0 value, 5 raw status, 6 mask, 7 clear (reads 0).
- R2: Config bits [5:2] hold the event select. A code k from 1 to 15 counts pulses on `ev_in[k]`, at most one per cycle. Code 0 disables the counter.
- R3: Control bit 0 is the global run enable. It reads back, and no counter advances while it is 0.
- R4: While `mon_en` is low, no counter advances and no status bit is set.
- R5: Writing 1 to control bit n+1 clears counter n at the next edge. This bit reads as 0. If a clear and a counted event fall in the same cycle, the counter becomes 0 and no interrupt is raised.
- R6: A counter that holds 0xFFFFFFFF keeps that value when further events arrive.
- R7: A write to a counter's value register loads it only while that counter's event select is 0. Otherwise the write is ignored.
- R8: Interrupt mode 1 (config bits [1:0] = 1) sets raw status bit n on every increment of counter n, at the same edge as the increment.
- R9: Interrupt mode 2 sets raw status bit n only on the increment that brings counter n to 0xFFFFFFFF.
- R10: `irq` is the OR of (raw status AND mask), using bits 1:0. Writing 1 to bit n of the clear register clears status bit n. A new set in the same cycle wins over the clear.
- R11: Counter 1's config and value registers sit one word below counter 0's, and each register affects only its own counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Master event-monitor enable |
| ev_in | input | 16 | Event pulses, bit k selected by code k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check four rules on every cycle:
- A counter moves by at most one per cycle.
- A counter at saturation stays there.
- A clear bit zeroes its counter.
- A value write aimed at a running counter cannot load it, and the counter still moves by at most one.

They also check that a low `mon_en` freezes both the counters and the status bits. Other behaviour can only be shown by the bench's scenarios:
- which event line a code selects
- the exact edge at which each interrupt mode sets a status bit
- a clear colliding with an event
- mask gating and clearing of the interrupt
- the descending address layout

A seeded random phase mixes register writes, monitor gating and event bursts against a bench model.

// File: rtl/cache_evt_mon.sv
module cache_evt_mon #(
  parameter int CW  = 32,
  parameter int NEV = 16,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mon_en,
  input  logic [NEV-1:0] ev_in,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq
);
  localparam int NC = 2;
  localparam int SW = $clog2(NEV);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_MASK = AW'(6);
  localparam logic [AW-1:0] A_CLR  = AW'(7);
  localparam logic [CW-1:0] SAT    = '1;

  logic                   run_q;
  logic [NC-1:0]          mask_q;
  logic [NC-1:0]          stat;
  logic [NC-1:0][CW-1:0]  cnt;
  logic [NC-1:0][SW+1:0]  cfg;

  wire ctrl_wr = reg_we && reg_addr == A_CTRL;
  wire clr_wr  = reg_we && reg_addr == A_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ctrl_wr) run_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[NC-1:0];
    end
  end

  for (genvar n = 0; n < NC; n++) begin : g_ctr
    localparam logic [AW-1:0] CFG_A = AW'(2 - n);
    localparam logic [AW-1:0] VAL_A = AW'(4 - n);
    logic [CW-1:0] c_q;
    logic [SW+1:0] f_q;
    logic          s_q;
    wire [SW-1:0] sel    = f_q[SW+1:2];
    wire [1:0]    mode   = f_q[1:0];
    wire          zap    = ctrl_wr && reg_wdata[n+1];
    wire          load   = reg_we && reg_addr == VAL_A && sel == '0;
    wire          step   = run_q && mon_en && sel != '0 && ev_in[sel] && c_q != SAT;
    wire          fire   = step && !zap &&
                           (mode == 2'd1 || (mode == 2'd2 && c_q == SAT - CW'(1)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_q <= '0;
        f_q <= '0;
        s_q <= 1'b0;
      end else begin
        if (zap)       c_q <= '0;
        else if (load) c_q <= reg_wdata[CW-1:0];
        else if (step) c_q <= c_q + CW'(1);
        if (reg_we && reg_addr == CFG_A) f_q <= reg_wdata[SW+1:0];
        if (fire)                        s_q <= 1'b1;
        else if (clr_wr && reg_wdata[n]) s_q <= 1'b0;
      end
    end

    assign cnt[n]  = c_q;
    assign cfg[n]  = f_q;
    assign stat[n] = s_q;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'b0, run_q};
      AW'(1):  reg_rdata = 32'(cfg[1]);
      AW'(2):  reg_rdata = 32'(cfg[0]);
      AW'(3):  reg_rdata = 32'(cnt[1]);
      AW'(4):  reg_rdata = 32'(cnt[0]);
      A_STAT:  reg_rdata = 32'(stat);
      A_MASK:  reg_rdata = 32'(mask_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(stat & mask_q);
endmodule

// File: rtl/cache_evt_mon_chk.sv
module cache_evt_mon_chk #(
  parameter int CW = 32,
  parameter int SW = 4,
  parameter int AW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mon_en,
  input logic                reg_we,
  input logic [AW-1:0]       reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [1:0][CW-1:0]  cnt,
  input logic [1:0][SW+1:0]  cfg,
  input logic [1:0]          stat
);
  localparam logic [CW-1:0] SAT = '1;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] == SAT && !reg_we |=> cnt[0] == SAT); // R6

  AST_MON_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en && !reg_we |=> $stable(cnt) && $stable(stat)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> (cnt[1] == $past(cnt[1]) || cnt[1] == $past(cnt[1]) + CW'(1))); // R2

  AST_CTR_ZAP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == AW'(0) && reg_wdata[1] |=> cnt[0] == '0); // R5

  AST_VAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == AW'(4) && cfg[0][SW+1:2] != '0
      |=> (cnt[0] == $past(cnt[0]) || cnt[0] == $past(cnt[0]) + CW'(1))); // R7
endmodule

bind cache_evt_mon cache_evt_mon_chk #(.CW(CW), .SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cnt(cnt), .cfg(cfg), .stat(stat)
);

// File: tb/cache_evt_mon_test.sv
module cache_evt_mon_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0, mon_en = 1, reg_we = 0, irq;
  logic [15:0] ev_in = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int total = 0, bad = 0;

  cache_evt_mon uut (.clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ev_in(ev_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] m_cnt [2];
  logic [5:0]  m_cfg [2];
  logic        m_en;
  logic [1:0]  m_raw, m_mask, nraw;
  logic [3:0]  s;
  logic        hit, rs, vw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_cfg[0] = 0; m_cfg[1] = 0;
      m_en = 0; m_raw = 0; m_mask = 0;
    end else begin
      nraw = m_raw;
      for (int n = 0; n < 2; n++) begin
        s   = m_cfg[n][5:2];
        hit = m_en && mon_en && s != 0 && ev_in[s] && m_cnt[n] != MAXV;
        rs  = reg_we && reg_addr == 0 && reg_wdata[n+1];
        vw  = reg_we && reg_addr == 3'(4 - n) && s == 0;
        if (reg_we && reg_addr == 7 && reg_wdata[n]) nraw[n] = 0;
        if (rs) m_cnt[n] = 0;
        else if (vw) m_cnt[n] = reg_wdata;
        else if (hit) begin
          if (m_cfg[n][1:0] == 1 || (m_cfg[n][1:0] == 2 && m_cnt[n] == MAXV - 1)) nraw[n] = 1;
          m_cnt[n] = m_cnt[n] + 1;
        end
      end
      m_raw = nraw;
      if (reg_we && reg_addr == 1) m_cfg[1] = reg_wdata[5:0];
      if (reg_we && reg_addr == 2) m_cfg[0] = reg_wdata[5:0];
      if (reg_we && reg_addr == 0) m_en = reg_wdata[0];
      if (reg_we && reg_addr == 6) m_mask = reg_wdata[1:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      0: return {31'b0, m_en};
      1: return {26'b0, m_cfg[1]};
      2: return {26'b0, m_cfg[0]};
      3: return m_cnt[1];
      4: return m_cnt[0];
      5: return {30'b0, m_raw};
      6: return {30'b0, m_mask};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); ev_in = 16'(1 << k);
    @(negedge clk); ev_in = '0;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rchk("R1 reset", 3'(a), 0);
    chk("R1 irq", {31'b0, irq}, 0);

    wr(4, 32'h100); rchk("R7 load", 4, 32'h100); rchk("R11 c1 untouched", 3, 0);
    wr(3, 32'h55);  rchk("R11 c1 load", 3, 32'h55); rchk("R11 c0 kept", 4, 32'h100);

    wr(2, 32'h0D); wr(0, 1); rchk("R3 run reads", 0, 1);
    pulse(3); pulse(3); rchk("R2 count sel3", 4, 32'h102);
    pulse(5); rchk("R2 other line", 4, 32'h102);
    rchk("R8 mode1 status", 5, 1); chk("R10 masked", {31'b0, irq}, 0);
    wr(6, 1); chk("R10 irq", {31'b0, irq}, 1);
    wr(7, 1); rchk("R10 clear", 5, 0); chk("R10 irq low", {31'b0, irq}, 0);
    wr(4, 32'hDEAD); rchk("R7 ignored", 4, 32'h102);

    wr(0, 0); pulse(3); rchk("R3 stopped", 4, 32'h102);
    wr(0, 1); mon_en = 0; pulse(3); rchk("R4 gated", 4, 32'h102);
    rchk("R4 no status", 5, 0); mon_en = 1;

    wr(0, 3); rchk("R5 zeroed", 4, 0); rchk("R5 bit reads 0", 0, 1);
    pulse(3); rchk("R5 counts again", 4, 1); wr(7, 3);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 3; ev_in = 16'h0008;
    @(negedge clk); reg_we = 0; ev_in = 0;
    rchk("R5 clear wins", 4, 0); rchk("R5 no irq on clash", 5, 0);

    wr(2, 0); wr(4, 32'hFFFF_FFFD); wr(2, 32'h0E); wr(7, 3);
    pulse(3); rchk("R9 below sat", 4, 32'hFFFF_FFFE); rchk("R9 no status", 5, 0);
    pulse(3); rchk("R6 reach sat", 4, MAXV); rchk("R9 status", 5, 1);
    wr(7, 1); pulse(3); rchk("R6 hold", 4, MAXV); rchk("R9 once", 5, 0);

    wr(1, 32'h3D); wr(6, 2); pulse(15);
    rchk("R2 c1 sel15", 3, 32'h56); chk("R10 c1 irq", {31'b0, irq}, 1);
    wr(7, 2);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      chk("R10 irq model", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
      if (cyc % 50 == 49) begin
        reg_we = 0; ev_in = 0;
        for (int a = 0; a < 8; a++) rchk("R1 random sweep", 3'(a), m_read(3'(a)));
      end else begin
        ev_in  = ($urandom % 2) ? 16'($urandom) : '0;
        mon_en = ($urandom % 16) != 0;
        reg_we = ($urandom % 4) == 0;
        reg_addr = 3'($urandom);
        reg_wdata = ($urandom % 4 == 0) ? (32'hFFFF_FFF0 | 32'($urandom % 16)) : $urandom;
        if (reg_addr == 0 && ($urandom % 2)) reg_wdata[0] = 1;
      end
    end
    @(negedge clk); reg_we = 0; ev_in = 0;
    for (int a = 0; a < 8; a++) rchk("R2 final", 3'(a), m_read(3'(a)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule